// File: doc/BRIEF.md
# Watch Timer with Buzzer Tone Output

This block is a free-running binary divider that runs on one of two tick sources: a pulse stream from a slow low-frequency oscillator (normally 32.768 kHz, brought in already synchronised as single-cycle `sub_tick` pulses) or a tick made internally by prescaling the fast system clock. The same divider chain drives three outputs at once. It raises a sticky interval flag and a one-cycle interrupt at a software-selected period. It provides a square-wave clock for a display controller. It produces a buzzer square wave at one of four tones.

Software controls the block through one 8-bit mode register. The register holds an enable bit, the tick source select, the interval choice and a two-bit tone code. A separate clear strobe acknowledges the interval flag. With a 32.768 kHz source, the long interval is 0.5 s (16384 ticks) and the short one is about 3.91 ms (128 ticks). The four tones are 2, 4, 8 and 16 kHz, and the display clock is 64 Hz.

Top module: `watch_buzz_timer`

## Requirements
- R1: After synchronous reset, `mode_rd` is 0x00 and `itv_flag`, `irq`, `buzz` and `disp_clk` are all 0.
- R2: A `mode_wr` strobe loads `mode_wdata` into the mode register, which `mode_rd` returns from the next cycle. The layout is bit 0 enable, bit 1 source select (1 = prescaled system clock), bit 2 interval select (1 = short), bits 5:4 tone code. Bits 3, 6 and 7 always read 0.
- R3: With the short interval selected, the flag sets on the 128th source tick after enable, and on every 128th tick after that.
- R4: With the long interval selected, the flag sets on the 16384th source tick after enable.
- R5: `itv_flag` stays at 1 until a `flag_clr` strobe. A boundary in the same cycle as a clear wins. `irq` is a one-cycle pulse, raised in the same cycle the flag sets.
- R6: While enabled, `buzz` equals bit (3 - tone code) of the tick count since enable, one cycle after the tick. Tone code 0 gives input/16, 1 gives /8, 2 gives /4 and 3 gives /2, each with 50% duty.
- R7: Clearing the enable bit zeroes the divider and prescaler, holds `buzz` and `disp_clk` low from the next cycle, and makes `sub_tick` have no effect. After re-enable, counting restarts from zero.
- R8: With source select = 1, the divider advances once every MAIN_PRESC system clocks, with the first tick MAIN_PRESC clocks after enable, and `sub_tick` is ignored.
- R9: `disp_clk` equals bit 8 of the tick count since enable (input/512), one cycle after the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 8 | Mode register write data |
| flag_clr | input | 1 | Clears the interval flag |
| sub_tick | input | 1 | Single-cycle pulses from the slow oscillator |
| mode_rd | output | 8 | Mode register readback |
| itv_flag | output | 1 | Sticky interval flag |
| irq | output | 1 | One-cycle interval interrupt pulse |
| buzz | output | 1 | Buzzer square wave |
| disp_clk | output | 1 | Divided clock for the display controller |

## Verification
The divider is driven by isolated `sub_tick` pulses, by the internal prescaled tick while `sub_tick` is held high, and across a disable and re-enable. These three patterns separate a correct source select and counter restart from a divider that counts the wrong ticks or keeps a stale count. The interval flag is checked exactly one tick before and exactly on the boundary for both rates, which exposes off-by-one tap or compare errors. Each tone code is compared tick by tick against the expected count bit, so a swapped or misindexed tap shows up directly.

// File: rtl/wt_pkg.sv
package wt_pkg;
  localparam int MODE_W = 8;
  // bits that software may set; the rest read as zero
  localparam logic [MODE_W-1:0] MODE_WMASK = 8'h37;

  typedef struct packed {
    logic [1:0] spare_hi;
    logic [1:0] tone;
    logic       spare3;
    logic       rate_short;
    logic       src_main;
    logic       enable;
  } wt_mode_t;
endpackage

// File: rtl/wt_tick_src.sv
module wt_tick_src #(
  parameter int MAIN_PRESC = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic src_main,
  input  logic sub_tick,
  output logic tick
);
  localparam int PW = (MAIN_PRESC > 1) ? $clog2(MAIN_PRESC) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(MAIN_PRESC - 1);

  logic [PW-1:0] presc_q;
  logic          presc_hit;

  assign presc_hit = (presc_q == PRESC_LAST);

  always_ff @(posedge clk) begin
    if (rst || !enable || !src_main) begin
      presc_q <= '0;
    end else if (presc_hit) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + PW'(1);
    end
  end

  always_comb begin
    if (!enable)       tick = 1'b0;
    else if (src_main) tick = presc_hit;
    else               tick = sub_tick;
  end
endmodule

// File: rtl/wt_divider.sv
module wt_divider #(
  parameter int DIV_W      = 14,
  parameter int SHORT_BITS = 7,
  parameter int LONG_BITS  = 14,
  parameter int TONE_BASE  = 0,
  parameter int DISP_TAP   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       tick,
  input  logic       rate_short,
  output logic [3:0] tone_taps,
  output logic       disp_tap,
  output logic       boundary
);
  logic [DIV_W-1:0] cnt_q;
  logic             short_end;
  logic             long_end;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign short_end = &cnt_q[SHORT_BITS-1:0];
  assign long_end  = &cnt_q[LONG_BITS-1:0];
  assign boundary  = tick && (rate_short ? short_end : long_end);

  genvar gi;
  generate
    for (gi = 0; gi < 4; gi++) begin : g_tap
      assign tone_taps[gi] = cnt_q[TONE_BASE + gi];
    end
  endgenerate

  assign disp_tap = cnt_q[DISP_TAP];
endmodule

// File: rtl/wt_outputs.sv
module wt_outputs (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic [1:0] tone,
  input  logic [3:0] tone_taps,
  input  logic       disp_tap,
  input  logic       boundary,
  input  logic       flag_clr,
  output logic       itv_flag,
  output logic       irq,
  output logic       buzz,
  output logic       disp_clk
);
  logic tone_sel;

  always_comb begin
    unique case (tone)
      2'd0:    tone_sel = tone_taps[3];
      2'd1:    tone_sel = tone_taps[2];
      2'd2:    tone_sel = tone_taps[1];
      default: tone_sel = tone_taps[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      itv_flag <= 1'b0;
      irq      <= 1'b0;
      buzz     <= 1'b0;
      disp_clk <= 1'b0;
    end else begin
      irq      <= boundary;
      buzz     <= enable & tone_sel;
      disp_clk <= enable & disp_tap;
      if (boundary)      itv_flag <= 1'b1;
      else if (flag_clr) itv_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/watch_buzz_timer.sv
module watch_buzz_timer #(
  parameter int MAIN_PRESC = 128,
  parameter int DIV_W      = 14,
  parameter int SHORT_BITS = 7,
  parameter int LONG_BITS  = 14,
  parameter int DISP_TAP   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [7:0] mode_wdata,
  input  logic       flag_clr,
  input  logic       sub_tick,
  output logic [7:0] mode_rd,
  output logic       itv_flag,
  output logic       irq,
  output logic       buzz,
  output logic       disp_clk
);
  import wt_pkg::*;

  wt_mode_t   mode_q;
  logic       tick;
  logic       boundary;
  logic [3:0] tone_taps;
  logic       disp_tap;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= '0;
    else if (mode_wr) mode_q <= wt_mode_t'(mode_wdata & MODE_WMASK);
  end

  assign mode_rd = mode_q;

  wt_tick_src #(.MAIN_PRESC(MAIN_PRESC)) u_src (
    .clk      (clk),
    .rst      (rst),
    .enable   (mode_q.enable),
    .src_main (mode_q.src_main),
    .sub_tick (sub_tick),
    .tick     (tick)
  );

  wt_divider #(
    .DIV_W      (DIV_W),
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS),
    .TONE_BASE  (0),
    .DISP_TAP   (DISP_TAP)
  ) u_div (
    .clk        (clk),
    .rst        (rst),
    .enable     (mode_q.enable),
    .tick       (tick),
    .rate_short (mode_q.rate_short),
    .tone_taps  (tone_taps),
    .disp_tap   (disp_tap),
    .boundary   (boundary)
  );

  wt_outputs u_out (
    .clk       (clk),
    .rst       (rst),
    .enable    (mode_q.enable),
    .tone      (mode_q.tone),
    .tone_taps (tone_taps),
    .disp_tap  (disp_tap),
    .boundary  (boundary),
    .flag_clr  (flag_clr),
    .itv_flag  (itv_flag),
    .irq       (irq),
    .buzz      (buzz),
    .disp_clk  (disp_clk)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] mode_rd,
  input logic       flag_clr,
  input logic       itv_flag,
  input logic       irq,
  input logic       buzz,
  input logic       disp_clk
);
  // R2: reserved mode bits never read as one
  assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_rd[7:6] == 2'b00) && !mode_rd[3]);

  // R5: interrupt is a single-cycle pulse
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R5: interrupt is accompanied by the flag
  assert_irq_flag_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> itv_flag);

  // R5: the flag only drops after a clear strobe
  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(itv_flag) |-> $past(flag_clr));

  // R7: disabled timer keeps its waveforms low
  assert_quiet_off_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_rd[0]) |-> (!buzz && !disp_clk));
endmodule

bind watch_buzz_timer wt_checker u_wt_checker (
  .clk      (clk),
  .rst      (rst),
  .mode_rd  (mode_rd),
  .flag_clr (flag_clr),
  .itv_flag (itv_flag),
  .irq      (irq),
  .buzz     (buzz),
  .disp_clk (disp_clk)
);

// File: tb/watch_buzz_timer_bench.sv
module watch_buzz_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRESC      = 8;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       flag_clr = 1'b0;
  logic       sub_tick = 1'b0;
  logic [7:0] mode_rd;
  logic       itv_flag, irq, buzz, disp_clk;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  watch_buzz_timer #(.MAIN_PRESC(PRESC)) u_watch_buzz_timer (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .flag_clr(flag_clr), .sub_tick(sub_tick), .mode_rd(mode_rd),
    .itv_flag(itv_flag), .irq(irq), .buzz(buzz), .disp_clk(disp_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [7:0] v);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic pulse_sub();
    sub_tick = 1'b1;
    @(negedge clk);
    sub_tick = 1'b0;
  endtask

  task automatic test_reset();
    check(mode_rd == 8'h00, "R1 mode", mode_rd, 0);
    check({itv_flag, irq, buzz, disp_clk} == 4'b0, "R1 outputs",
          {itv_flag, irq, buzz, disp_clk}, 0);
  endtask

  task automatic test_mode_rw();
    write_mode(8'hFF);
    check(mode_rd == 8'h37, "R2 mask", mode_rd, 8'h37);
    write_mode(8'h15);
    check(mode_rd == 8'h15, "R2 load", mode_rd, 8'h15);
    write_mode(8'h00);
  endtask

  task automatic test_short();
    clear_flag();
    write_mode(8'h05);
    for (int i = 0; i < 127; i++) pulse_sub();
    check(itv_flag == 1'b0, "R3 before boundary", itv_flag, 0);
    pulse_sub();
    check(itv_flag == 1'b1, "R3 at boundary", itv_flag, 1);
    check(irq == 1'b1, "R5 irq raised", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R5 irq one cycle", irq, 0);
  endtask

  task automatic test_sticky();
    for (int i = 0; i < 5; i++) pulse_sub();
    check(itv_flag == 1'b1, "R5 flag held", itv_flag, 1);
    clear_flag();
    check(itv_flag == 1'b0, "R5 flag cleared", itv_flag, 0);
    for (int i = 0; i < 122; i++) pulse_sub();
    check(itv_flag == 1'b0, "R3 second period early", itv_flag, 0);
    pulse_sub();
    check(itv_flag == 1'b1, "R3 second period", itv_flag, 1);
    write_mode(8'h00);
  endtask

  task automatic test_long();
    clear_flag();
    write_mode(8'h01);
    for (int i = 0; i < 16383; i++) pulse_sub();
    check(itv_flag == 1'b0, "R4 before boundary", itv_flag, 0);
    pulse_sub();
    check(itv_flag == 1'b1, "R4 at boundary", itv_flag, 1);
    write_mode(8'h00);
    clear_flag();
  endtask

  task automatic test_tones();
    for (int t = 0; t < 4; t++) begin
      write_mode(8'h00);
      write_mode(8'h01 | 8'(t << 4));
      for (int i = 1; i <= 40; i++) begin
        pulse_sub();
        @(negedge clk);
        check(buzz == 1'((i >> (3 - t)) & 1), $sformatf("R6 tone %0d tick %0d", t, i),
              buzz, (i >> (3 - t)) & 1);
      end
    end
    write_mode(8'h00);
  endtask

  task automatic test_disp();
    write_mode(8'h01);
    for (int i = 0; i < 255; i++) pulse_sub();
    @(negedge clk);
    check(disp_clk == 1'b0, "R9 before bit8", disp_clk, 0);
    pulse_sub();
    @(negedge clk);
    check(disp_clk == 1'b1, "R9 bit8 set", disp_clk, 1);
    write_mode(8'h00);
  endtask

  task automatic test_disable();
    write_mode(8'h31);
    for (int i = 0; i < 5; i++) pulse_sub();
    @(negedge clk);
    check(buzz == 1'b1, "R6 tone3 count5", buzz, 1);
    write_mode(8'h30);
    @(negedge clk);
    check(buzz == 1'b0, "R7 buzz low when off", buzz, 0);
    for (int i = 0; i < 3; i++) pulse_sub();
    @(negedge clk);
    check(buzz == 1'b0 && disp_clk == 1'b0, "R7 ticks ignored when off", buzz, 0);
    write_mode(8'h31);
    pulse_sub();
    @(negedge clk);
    check(buzz == 1'b1, "R7 restart count1", buzz, 1);
    pulse_sub();
    @(negedge clk);
    check(buzz == 1'b0, "R7 restart count2", buzz, 0);
    write_mode(8'h00);
  endtask

  task automatic test_main_src();
    clear_flag();
    sub_tick = 1'b1;
    write_mode(8'h07);
    repeat (PRESC * 128 - 1) @(negedge clk);
    check(itv_flag == 1'b0, "R8 before boundary", itv_flag, 0);
    @(negedge clk);
    check(itv_flag == 1'b1, "R8 at boundary", itv_flag, 1);
    sub_tick = 1'b0;
    write_mode(8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_mode_rw();
    test_short();
    test_sticky();
    test_long();
    test_tones();
    test_disp();
    test_disable();
    test_main_src();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule